// File: doc/BRIEF.md
# Load-Use Interlock and Branch Squash Controller

This block makes the stall and flush decisions for a five-stage in-order pipeline with fetch, decode, execute, memory and write-back stages. Each cycle it compares the source registers of the instruction now in decode with the destination of the instruction in execute. If the execute instruction is a load that writes one of those registers, the block holds the program counter and the fetch/decode register for one cycle. In that same cycle it selects a bubble for the decode/execute register. The load moves on, and its data later reaches the waiting instruction over the write-back forwarding path.

Branches are resolved in execute, and the policy is predict-not-taken. The fall-through path keeps being fetched. When a branch turns out taken, the two younger instructions already in fetch and decode are squashed into nops, and the program counter is steered to the branch target. A not-taken branch costs nothing.

The outputs are combinational from the current inputs and one internal flag. That flag records whether the previous cycle was an interlock cycle. The datapath registers and multiplexers sit outside the block.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: While `rst` is high, the outputs are idle: `pc_we` = 1, `ifid_we` = 1, `idex_bubble` = 0, `ifid_flush` = 0, `idex_flush` = 0, `pc_sel` = 0 and `redirect_pc` = 0. A cycle spent in reset counts as a non-interlock cycle for R5.
- R2: When `ex_memread` = 1, `ex_dst` is nonzero and equals a decode source register, `br_taken` = 0, and the previous cycle was not an interlock, the same cycle has `idex_bubble` = 1, `pc_we` = 0 and `ifid_we` = 0. Both flush outputs and `pc_sel` stay 0.
- R3: When `ex_memread` = 0, or `ex_dst` matches no decode source, no interlock is raised and `pc_we` = `ifid_we` = 1.
- R4: A load whose `ex_dst` is register 0 never raises an interlock, even if a decode source is also 0.
- R5: An interlock lasts exactly one cycle. In the cycle right after an interlock no interlock is raised, even if the inputs still match. One cycle later a match interlocks again.
- R6: When `br_taken` = 1, the same cycle has `ifid_flush` = 1, `idex_flush` = 1, `pc_sel` = 1 (1 selects the branch target, 0 the sequential address), `pc_we` = 1, `ifid_we` = 1 and `redirect_pc` = `br_target`.
- R7: When `br_taken` = 0, `ifid_flush` = 0, `idex_flush` = 0, `pc_sel` = 0 and `redirect_pc` = 0.
- R8: When a taken branch and a load-use match occur in the same cycle, the branch squash wins: the outputs are those of R6 with `idex_bubble` = 0. That cycle does not count as an interlock for R5.
- R9: Each of the `NSRC` decode sources is compared on its own. Source i sits in bits [i*REG_AW +: REG_AW] of `id_src`, and a match on any one of them is enough for R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| id_src | input | NSRC*REG_AW | Source register numbers of the decode-stage instruction, source i at bits [i*REG_AW +: REG_AW] |
| ex_memread | input | 1 | The execute-stage instruction reads data memory (a load) |
| ex_dst | input | REG_AW | Destination register of the execute-stage instruction |
| br_taken | input | 1 | The branch in execute resolved as taken |
| br_target | input | ADDR_W | Target address of that branch |
| pc_we | output | 1 | Program counter write enable |
| ifid_we | output | 1 | Fetch/decode register write enable |
| idex_bubble | output | 1 | Load all-zero control into decode/execute (interlock bubble) |
| ifid_flush | output | 1 | Replace the fetch/decode instruction with a nop |
| idex_flush | output | 1 | Replace the decode/execute control with a nop |
| pc_sel | output | 1 | Next-PC source: 0 sequential, 1 branch target |
| redirect_pc | output | ADDR_W | Branch target when taken, otherwise zero |

## Verification
A taken branch and a load-use match can occur in the same cycle. The sweep provokes this by driving every combination of load flag, destination, both sources and branch outcome, including all cases where both are active at once. For those cases the squash outputs must appear with no bubble, and the held pattern on the next edge must show whether the interlock flag was wrongly set. The second collision is a match that persists after an interlock. Each pattern is held for three edges, so the bench sees the interlock, the forced release and the re-arm in sequence.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    typedef enum logic {
        PC_SEQ    = 1'b0,
        PC_BRANCH = 1'b1
    } pc_src_e;

    typedef struct packed {
        logic    pc_we;
        logic    ifid_we;
        logic    idex_bubble;
        logic    ifid_flush;
        logic    idex_flush;
        pc_src_e pc_src;
    } hz_ctrl_t;

    function automatic hz_ctrl_t hz_idle();
        hz_ctrl_t c;
        c.pc_we       = 1'b1;
        c.ifid_we     = 1'b1;
        c.idex_bubble = 1'b0;
        c.ifid_flush  = 1'b0;
        c.idex_flush  = 1'b0;
        c.pc_src      = PC_SEQ;
        return c;
    endfunction

    function automatic hz_ctrl_t hz_interlock();
        hz_ctrl_t c;
        c             = hz_idle();
        c.pc_we       = 1'b0;
        c.ifid_we     = 1'b0;
        c.idex_bubble = 1'b1;
        return c;
    endfunction

    function automatic hz_ctrl_t hz_squash();
        hz_ctrl_t c;
        c            = hz_idle();
        c.ifid_flush = 1'b1;
        c.idex_flush = 1'b1;
        c.pc_src     = PC_BRANCH;
        return c;
    endfunction

endpackage

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2
) (
    input  logic [NSRC-1:0][REG_AW-1:0] src_regs,
    input  logic                        ld_valid,
    input  logic [REG_AW-1:0]           ld_dst,
    output logic                        hit
);
    localparam logic [REG_AW-1:0] ZERO_REG = '0;

    logic [NSRC-1:0] eq;

    genvar gi;
    generate
        for (gi = 0; gi < NSRC; gi++) begin : g_cmp
            assign eq[gi] = (src_regs[gi] == ld_dst);
        end
    endgenerate

    always_comb begin
        hit = ld_valid && (ld_dst != ZERO_REG) && (|eq);
    end
endmodule

// File: rtl/hz_branch_redirect.sv
module hz_branch_redirect #(
    parameter int ADDR_W = 32
) (
    input  logic              active,
    input  logic              taken,
    input  logic [ADDR_W-1:0] target,
    output logic              kill,
    output logic [ADDR_W-1:0] redirect
);
    always_comb begin
        kill     = active && taken;
        redirect = kill ? target : '0;
    end
endmodule

// File: rtl/hz_arbiter.sv
module hz_arbiter
    import hazard_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ld_hit,
    input  logic     kill,
    output hz_ctrl_t ctrl
);
    logic held_q;
    logic stall;

    always_comb begin
        stall = !rst && ld_hit && !kill && !held_q;
        if (rst)
            ctrl = hz_idle();
        else if (kill)
            ctrl = hz_squash();
        else if (stall)
            ctrl = hz_interlock();
        else
            ctrl = hz_idle();
    end

    always_ff @(posedge clk) begin
        if (rst)
            held_q <= 1'b0;
        else
            held_q <= stall;
    end
endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
    import hazard_pkg::*;
#(
    parameter int REG_AW = 5,
    parameter int NSRC   = 2,
    parameter int ADDR_W = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NSRC*REG_AW-1:0]   id_src,
    input  logic                     ex_memread,
    input  logic [REG_AW-1:0]        ex_dst,
    input  logic                     br_taken,
    input  logic [ADDR_W-1:0]        br_target,
    output logic                     pc_we,
    output logic                     ifid_we,
    output logic                     idex_bubble,
    output logic                     ifid_flush,
    output logic                     idex_flush,
    output logic                     pc_sel,
    output logic [ADDR_W-1:0]        redirect_pc
);
    logic [NSRC-1:0][REG_AW-1:0] src_arr;
    logic                        ld_hit;
    logic                        kill;
    hz_ctrl_t                    ctrl;

    genvar gs;
    generate
        for (gs = 0; gs < NSRC; gs++) begin : g_unpack
            assign src_arr[gs] = id_src[gs*REG_AW +: REG_AW];
        end
    endgenerate

    hz_loaduse_detect #(.REG_AW(REG_AW), .NSRC(NSRC)) u_detect (
        .src_regs (src_arr),
        .ld_valid (ex_memread),
        .ld_dst   (ex_dst),
        .hit      (ld_hit)
    );

    hz_branch_redirect #(.ADDR_W(ADDR_W)) u_redirect (
        .active   (!rst),
        .taken    (br_taken),
        .target   (br_target),
        .kill     (kill),
        .redirect (redirect_pc)
    );

    hz_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .ld_hit (ld_hit),
        .kill   (kill),
        .ctrl   (ctrl)
    );

    always_comb begin
        pc_we       = ctrl.pc_we;
        ifid_we     = ctrl.ifid_we;
        idex_bubble = ctrl.idex_bubble;
        ifid_flush  = ctrl.ifid_flush;
        idex_flush  = ctrl.idex_flush;
        pc_sel      = (ctrl.pc_src == PC_BRANCH);
    end
endmodule

// File: rtl/pipe_hazard_ctrl_chk.sv
module pipe_hazard_ctrl_chk #(
    parameter int REG_AW = 5,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              ex_memread,
    input logic [REG_AW-1:0] ex_dst,
    input logic              br_taken,
    input logic [ADDR_W-1:0] br_target,
    input logic              pc_we,
    input logic              ifid_we,
    input logic              idex_bubble,
    input logic              ifid_flush,
    input logic              idex_flush,
    input logic              pc_sel,
    input logic [ADDR_W-1:0] redirect_pc
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |-> (pc_we && ifid_we && !idex_bubble && !ifid_flush && !idex_flush && !pc_sel
                 && redirect_pc == '0));

    assert_bubble_holds_R2: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |-> (!pc_we && !ifid_we && !ifid_flush && !idex_flush));

    assert_no_load_no_bubble_R3: assert property (@(posedge clk) disable iff (rst)
        !ex_memread |-> !idex_bubble);

    assert_reg_zero_exempt_R4: assert property (@(posedge clk) disable iff (rst)
        (ex_memread && ex_dst == '0 && !br_taken) |-> !idex_bubble);

    assert_single_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        idex_bubble |=> !idex_bubble);

    assert_squash_R6: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> (ifid_flush && idex_flush && pc_sel && pc_we && ifid_we
                      && redirect_pc == br_target));

    assert_fallthrough_R7: assert property (@(posedge clk) disable iff (rst)
        !br_taken |-> (!ifid_flush && !idex_flush && !pc_sel && redirect_pc == '0));

    assert_squash_wins_R8: assert property (@(posedge clk) disable iff (rst)
        br_taken |-> !idex_bubble);
endmodule

bind pipe_hazard_ctrl pipe_hazard_ctrl_chk #(.REG_AW(REG_AW), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ex_memread  (ex_memread),
    .ex_dst      (ex_dst),
    .br_taken    (br_taken),
    .br_target   (br_target),
    .pc_we       (pc_we),
    .ifid_we     (ifid_we),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush),
    .idex_flush  (idex_flush),
    .pc_sel      (pc_sel),
    .redirect_pc (redirect_pc)
);

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;
    localparam int RW = 3;
    localparam int NS = 2;
    localparam int AW = 8;
    localparam int NREG = 1 << RW;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS*RW-1:0]  id_src = '0;
    logic              ex_memread = 1'b0;
    logic [RW-1:0]     ex_dst = '0;
    logic              br_taken = 1'b0;
    logic [AW-1:0]     br_target = '0;
    logic              pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush, pc_sel;
    logic [AW-1:0]     redirect_pc;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    pipe_hazard_ctrl #(.REG_AW(RW), .NSRC(NS), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .id_src(id_src), .ex_memread(ex_memread),
        .ex_dst(ex_dst), .br_taken(br_taken), .br_target(br_target),
        .pc_we(pc_we), .ifid_we(ifid_we), .idex_bubble(idex_bubble),
        .ifid_flush(ifid_flush), .idex_flush(idex_flush), .pc_sel(pc_sel),
        .redirect_pc(redirect_pc)
    );

    // Expected vector {pc_we, ifid_we, bubble, ifid_flush, idex_flush, pc_sel}
    function automatic logic [5:0] model(input logic r, input logic mr, input logic [RW-1:0] d,
                                         input logic [RW-1:0] a, input logic [RW-1:0] b,
                                         input logic tk, input logic held);
        logic match;
        match = mr && (d != 0) && (a == d || b == d);
        if (r)                  return 6'b110000;
        else if (tk)            return 6'b110111;
        else if (match && !held) return 6'b001000;
        else                    return 6'b110000;
    endfunction

    function automatic string tag_of(input logic r, input logic mr, input logic [RW-1:0] d,
                                     input logic [RW-1:0] a, input logic [RW-1:0] b,
                                     input logic tk, input logic held);
        logic match;
        match = mr && (d != 0) && (a == d || b == d);
        if (r)                               return "R1";
        if (tk && match)                     return "R8";
        if (tk)                              return "R6";
        if (match && held)                   return "R5";
        if (match && a != d)                 return "R9";
        if (match)                           return "R2";
        if (mr && d == 0 && (a == 0 || b == 0)) return "R4";
        return "R3 R7";
    endfunction

    task automatic check_now(input logic held);
        logic [5:0]    act, exp;
        logic [AW-1:0] exp_pc;
        string         t;
        logic [RW-1:0] a, b;
        a = id_src[RW-1:0];
        b = id_src[2*RW-1:RW];
        exp    = model(rst, ex_memread, ex_dst, a, b, br_taken, held);
        exp_pc = (!rst && br_taken) ? br_target : '0;
        t      = tag_of(rst, ex_memread, ex_dst, a, b, br_taken, held);
        act    = {pc_we, ifid_we, idex_bubble, ifid_flush, idex_flush, pc_sel};
        checks++;
        if (act !== exp || redirect_pc !== exp_pc) begin
            fails++;
            $display("FAIL %s: ctrl=%b pc=%h expected ctrl=%b pc=%h (mr=%0d dst=%0d a=%0d b=%0d tk=%0d)",
                     t, act, redirect_pc, exp, exp_pc, ex_memread, ex_dst, a, b, br_taken);
        end
    endtask

    function automatic logic stalls(input logic held);
        logic [5:0] e;
        e = model(rst, ex_memread, ex_dst, id_src[RW-1:0], id_src[2*RW-1:RW], br_taken, held);
        return e[3];
    endfunction

    initial begin : watchdog
        #1000000;
        fails++;
        checks++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic h;
        // R1: reset dominates hazard and branch inputs
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ex_memread = 1'b1;
            ex_dst     = RW'(k + 1);
            id_src     = {RW'(k + 1), RW'(k + 1)};
            br_taken   = k[0];
            br_target  = 8'h3C;
            #3 check_now(1'b0);
        end
        @(negedge clk);
        rst = 1'b0;
        ex_memread = 1'b0;
        br_taken   = 1'b0;
        for (int mr = 0; mr < 2; mr++)
            for (int d = 0; d < NREG; d++)
                for (int a = 0; a < NREG; a++)
                    for (int b = 0; b < NREG; b++)
                        for (int tk = 0; tk < 2; tk++) begin
                            @(negedge clk);
                            ex_memread = 1'b0;
                            br_taken   = 1'b0;
                            @(negedge clk);
                            ex_memread = mr[0];
                            ex_dst     = RW'(d);
                            id_src     = {RW'(b), RW'(a)};
                            br_taken   = tk[0];
                            br_target  = AW'(8'hA5 ^ (d * 16 + a * 4 + b));
                            h = 1'b0;
                            for (int rep = 0; rep < 3; rep++) begin
                                if (rep > 0) @(negedge clk);
                                #3 check_now(h);
                                h = stalls(h);
                            end
                        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule